// File: doc/BRIEF.md
# Framebuffer Dirty-Region Tracker

This block watches the write traffic that a processor sends into a framebuffer and marks which parts of that buffer have changed since the last screen update. The buffer occupies a power-of-two byte window. The window is cut into 64 equal segments. Each write that lands inside the window sets the flag of the segment it hits.

When the display path asks for a refresh, the block takes a snapshot of the flags and clears them in the same cycle. It finds the lowest and the highest marked segments. From these it derives a partial refresh rectangle: a first line and an address aligned to that line, plus a line count clamped to the visible height. Two sequential dividers turn byte offsets into line numbers. The block reports busy while the dividers run and then pulses a valid strobe with the result. If nothing was written, it pulses an error strobe in place of the result.

Top module: `dirty_seg_tracker`

## Requirements
- R1: After synchronous reset `busy`, `upd_valid` and `upd_err` are all 0.
- R2: A write with `wr_valid`=1 whose address satisfies 0 <= addr-`win_base` < 2^`win_log2` marks segment (addr-`win_base`) >> (`win_log2`-6). Here `win_log2` >= 6.
- R3: The start line is floor(lowest marked segment × segment size / `line_bytes`). The segment size is 2^(`win_log2`-6). `upd_start_addr` = start line × `line_bytes` + `win_base`.
- R4: The end line is floor((highest marked segment + 1) × segment size / `line_bytes`) + 1, limited to at most `vres`. `upd_height` = end line − start line, or 0 if that difference would be negative.
- R5: A refresh request that finds no marked segment pulses `upd_err` for one cycle and produces no `upd_valid`.
- R6: Accepting a refresh request clears every segment flag, so a second request with no writes in between ends in `upd_err`.
- R7: A write in the same cycle as an accepted refresh request is left out of that result and counted in the following one.
- R8: `busy` is 1 from the cycle after an accepted request until its result is output. Requests that arrive while `busy` is 1 are ignored and produce no further result.
- R9: `upd_valid` and `upd_err` are single-cycle pulses and are never high together.
- R10: Writes below `win_base` or at or above `win_base`+2^`win_log2` change no segment flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Snooped write is present |
| wr_addr | input | AW | Snooped write byte address |
| win_base | input | AW | Framebuffer window base address |
| win_log2 | input | LOGW | log2 of the window size in bytes (>= 6) |
| line_bytes | input | LW | Bytes per display line (nonzero) |
| vres | input | LW | Visible line count |
| refresh_req | input | 1 | Request a dirty-region result |
| busy | output | 1 | Result computation in progress |
| upd_valid | output | 1 | One-cycle strobe: result fields valid |
| upd_err | output | 1 | One-cycle strobe: request found nothing dirty |
| upd_start_addr | output | AW | Line-aligned refresh start address |
| upd_start_line | output | LW | First line to refresh |
| upd_height | output | LW | Number of lines to refresh |

## Verification
On every cycle the assertions check four things. The two result strobes must never be high together. An accepted request must raise busy. Every strobe must follow a busy cycle. A valid rectangle must not run past the visible height. Two further checks cover the segment flags and the divider: flags left after a capture come only from a same-cycle write, and each divider remainder must be below its divisor. Only the bench scenarios can show the rest. These are the exact line and address arithmetic, the clamp, the rejection of writes outside the window, the handling of a write that races the clear, and the dropping of requests made while busy.

// File: rtl/dst_pkg.sv
package dst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_DIV
  } dst_state_t;
endpackage

// File: rtl/dst_seg_bitmap.sv
module dst_seg_bitmap #(
  parameter int AW   = 32,
  parameter int NSEG = 64,
  parameter int LOGW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_valid,
  input  logic [AW-1:0]   wr_addr,
  input  logic [AW-1:0]   win_base,
  input  logic [LOGW-1:0] win_log2,
  input  logic            capture,
  output logic [NSEG-1:0] snap
);
  localparam int SW = $clog2(NSEG);

  logic [NSEG-1:0] bits;
  logic [AW-1:0]   off;
  logic [AW-1:0]   idx_full;
  logic [LOGW-1:0] seg_sh;
  logic            in_win;
  logic [NSEG-1:0] hit_vec;

  assign off      = wr_addr - win_base;
  assign seg_sh   = win_log2 - LOGW'(SW);
  assign in_win   = ((off >> win_log2) == '0);
  assign idx_full = off >> seg_sh;
  assign hit_vec  = (wr_valid && in_win) ? (NSEG'(1) << idx_full[SW-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits <= '0;
      snap <= '0;
    end else begin
      bits <= (capture ? '0 : bits) | hit_vec;
      if (capture) snap <= bits;
    end
  end

  p_clear_keep_r7: assert property (@(posedge clk) disable iff (rst)
    capture |=> ($countones(bits) <= 1));
endmodule

// File: rtl/dst_bit_scan.sv
module dst_bit_scan #(
  parameter int NSEG = 64,
  parameter int SW   = 6
) (
  input  logic [NSEG-1:0] vec,
  output logic [SW-1:0]   lo_idx,
  output logic [SW:0]     hi_cnt,
  output logic            any
);
  always_comb begin
    lo_idx = '0;
    for (int i = NSEG - 1; i >= 0; i--) begin
      if (vec[i]) lo_idx = SW'(i);
    end
  end

  always_comb begin
    hi_cnt = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (vec[i]) hi_cnt = (SW+1)'(i + 1);
    end
  end

  assign any = |vec;
endmodule

// File: rtl/dst_seq_div.sv
module dst_seq_div #(
  parameter int NW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [NW-1:0] quo,
  output logic          done
);
  localparam int CW = $clog2(NW + 1);

  logic [DW:0]   rem;
  logic [DW:0]   rem_sh;
  logic [DW:0]   rem_nx;
  logic          ge;
  logic [CW-1:0] cnt;
  logic          run;

  assign rem_sh = {rem[DW-1:0], quo[NW-1]};
  assign ge     = (rem_sh >= {1'b0, divisor});
  assign rem_nx = ge ? (rem_sh - {1'b0, divisor}) : rem_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      quo  <= '0;
      rem  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      quo  <= dividend;
      rem  <= '0;
      cnt  <= CW'(NW);
      run  <= 1'b1;
      done <= 1'b0;
    end else if (run) begin
      quo <= {quo[NW-2:0], ge};
      rem <= rem_nx;
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        run  <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  p_rem_below_divisor_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (rem < {1'b0, divisor}));
endmodule

// File: rtl/dirty_seg_tracker.sv
module dirty_seg_tracker #(
  parameter int AW   = 32,
  parameter int LW   = 16,
  parameter int NSEG = 64,
  parameter int LOGW = $clog2(AW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_valid,
  input  logic [AW-1:0]   wr_addr,
  input  logic [AW-1:0]   win_base,
  input  logic [LOGW-1:0] win_log2,
  input  logic [LW-1:0]   line_bytes,
  input  logic [LW-1:0]   vres,
  input  logic            refresh_req,
  output logic            busy,
  output logic            upd_valid,
  output logic            upd_err,
  output logic [AW-1:0]   upd_start_addr,
  output logic [LW-1:0]   upd_start_line,
  output logic [LW-1:0]   upd_height
);
  import dst_pkg::*;
  localparam int SW = $clog2(NSEG);

  dst_state_t      state;
  logic            capture;
  logic [NSEG-1:0] snap;
  logic [SW-1:0]   lo_idx;
  logic [SW:0]     hi_cnt;
  logic            any;
  logic [LOGW-1:0] seg_shift;
  logic [AW-1:0]   start_off;
  logic [AW-1:0]   end_off;
  logic            div_start;
  logic [AW-1:0]   q_start;
  logic [AW-1:0]   q_end;
  logic            done_s;
  logic            done_e;
  logic [AW:0]     el_raw;
  logic [AW:0]     el_clamp;
  logic [AW:0]     vres_x;
  logic [AW:0]     sl_x;
  logic [AW:0]     ht;
  logic [AW-1:0]   addr_c;

  assign capture   = refresh_req && (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign div_start = (state == ST_SCAN) && any;

  dst_seg_bitmap #(.AW(AW), .NSEG(NSEG), .LOGW(LOGW)) u_bitmap (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .win_base(win_base), .win_log2(win_log2), .capture(capture), .snap(snap)
  );

  dst_bit_scan #(.NSEG(NSEG), .SW(SW)) u_scan (
    .vec(snap), .lo_idx(lo_idx), .hi_cnt(hi_cnt), .any(any)
  );

  assign seg_shift = win_log2 - LOGW'(SW);
  assign start_off = AW'(lo_idx) << seg_shift;
  assign end_off   = AW'(hi_cnt) << seg_shift;

  dst_seq_div #(.NW(AW), .DW(LW)) u_div_start (
    .clk(clk), .rst(rst), .start(div_start), .dividend(start_off),
    .divisor(line_bytes), .quo(q_start), .done(done_s)
  );

  dst_seq_div #(.NW(AW), .DW(LW)) u_div_end (
    .clk(clk), .rst(rst), .start(div_start), .dividend(end_off),
    .divisor(line_bytes), .quo(q_end), .done(done_e)
  );

  always_comb begin
    el_raw   = {1'b0, q_end} + (AW+1)'(1);
    vres_x   = (AW+1)'(vres);
    el_clamp = (el_raw > vres_x) ? vres_x : el_raw;
    sl_x     = {1'b0, q_start};
    ht       = (el_clamp > sl_x) ? (el_clamp - sl_x) : '0;
    addr_c   = q_start * AW'(line_bytes) + win_base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      upd_valid      <= 1'b0;
      upd_err        <= 1'b0;
      upd_start_addr <= '0;
      upd_start_line <= '0;
      upd_height     <= '0;
    end else begin
      upd_valid <= 1'b0;
      upd_err   <= 1'b0;
      case (state)
        ST_IDLE: if (capture) state <= ST_SCAN;
        ST_SCAN: begin
          if (any) state <= ST_DIV;
          else begin
            state   <= ST_IDLE;
            upd_err <= 1'b1;
          end
        end
        ST_DIV: if (done_s && done_e) begin
          state          <= ST_IDLE;
          upd_valid      <= 1'b1;
          upd_start_addr <= addr_c;
          upd_start_line <= LW'(q_start);
          upd_height     <= LW'(ht);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (rst)
    !(upd_valid && upd_err));
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (refresh_req && !busy) |=> busy);
  p_strobe_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (upd_valid || upd_err) |-> $past(busy));
  p_height_fits_r4: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_height != '0) |->
      (({1'b0, upd_start_line} + {1'b0, upd_height}) <= {1'b0, vres}));
endmodule

// File: tb/dirty_seg_tracker_bench.sv
`timescale 1ns/1ps
module dirty_seg_tracker_bench;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int LOGW = 6;
  localparam logic [AW-1:0] BASE = 32'h1000_0000;
  localparam int NV = 5;
  // stimulus offsets and expected line, address offset, height (R2, R3, R4)
  localparam int V_OFF0 [NV] = '{0,   130, 3210, 2560, 1000};
  localparam int V_OFF1 [NV] = '{0,   700, 3210, 3845, 64};
  localparam int V_LINE [NV] = '{0,   1,   32,   25,   0};
  localparam int V_ADDR [NV] = '{0,   100, 3200, 2500, 0};
  localparam int V_HT   [NV] = '{1,   7,   1,    10,   11};

  logic clk = 0;
  logic rst;
  logic wr_valid;
  logic [AW-1:0] wr_addr;
  logic [LOGW-1:0] win_log2;
  logic [LW-1:0] line_bytes, vres;
  logic refresh_req;
  logic busy, upd_valid, upd_err;
  logic [AW-1:0] upd_start_addr;
  logic [LW-1:0] upd_start_line, upd_height;

  int checks = 0;
  int errors = 0;
  logic got_v, got_e;
  logic [AW-1:0] got_addr;
  logic [LW-1:0] got_line, got_h;

  always #2.5 clk = ~clk;

  dirty_seg_tracker #(.AW(AW), .LW(LW)) u_dirty_seg_tracker (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .win_base(BASE), .win_log2(win_log2), .line_bytes(line_bytes), .vres(vres),
    .refresh_req(refresh_req), .busy(busy), .upd_valid(upd_valid), .upd_err(upd_err),
    .upd_start_addr(upd_start_addr), .upd_start_line(upd_start_line), .upd_height(upd_height)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_result();
    got_v = 0;
    got_e = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (upd_valid || upd_err) begin
        got_v = upd_valid;
        got_e = upd_err;
        got_addr = upd_start_addr;
        got_line = upd_start_line;
        got_h = upd_height;
        break;
      end
    end
  endtask

  task automatic refresh(input logic with_wr, input logic [AW-1:0] a);
    @(negedge clk);
    refresh_req = 1'b1;
    if (with_wr) begin
      wr_valid = 1'b1;
      wr_addr  = a;
    end
    @(negedge clk);
    refresh_req = 1'b0;
    wr_valid = 1'b0;
    wait_result();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; wr_valid = 0; wr_addr = '0; refresh_req = 0;
    win_log2 = 6'd12; line_bytes = 16'd100; vres = 16'd35;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 valid", upd_valid, 0);
    check("R1 err", upd_err, 0);

    // vector table: R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      do_write(BASE + V_OFF0[v]);
      do_write(BASE + V_OFF1[v]);
      refresh(1'b0, '0);
      check("R2 valid", got_v, 1);
      check("R3 start_line", got_line, V_LINE[v]);
      check("R3 start_addr", got_addr, BASE + V_ADDR[v]);
      check("R4 height", got_h, V_HT[v]);
    end

    // R5 empty request gives error only
    refresh(1'b0, '0);
    check("R5 err", got_e, 1);
    check("R5 no valid", got_v, 0);

    // R6 bitmap cleared after capture
    do_write(BASE + 640);
    refresh(1'b0, '0);
    check("R6 first valid", got_v, 1);
    refresh(1'b0, '0);
    check("R6 second err", got_e, 1);

    // R7 same-cycle write kept for next period
    do_write(BASE);
    refresh(1'b1, BASE + 2000);
    check("R7 first line", got_line, 0);
    check("R7 first height", got_h, 1);
    refresh(1'b0, '0);
    check("R7 kept valid", got_v, 1);
    check("R7 kept line", got_line, 19);
    check("R7 kept addr", got_addr, BASE + 1900);
    check("R7 kept height", got_h, 2);

    // R10 out-of-window writes ignored
    do_write(BASE - 4);
    do_write(BASE + 4096);
    do_write(BASE + 640);
    refresh(1'b0, '0);
    check("R10 line", got_line, 6);
    check("R10 addr", got_addr, BASE + 600);
    check("R10 height", got_h, 2);
    do_write(BASE + 32'h0010_0000);
    refresh(1'b0, '0);
    check("R10 only outside err", got_e, 1);

    // R8 busy and ignored requests
    do_write(BASE + 130);
    @(negedge clk);
    refresh_req = 1'b1;
    @(negedge clk);
    refresh_req = 1'b0;
    check("R8 busy after accept", busy, 1);
    refresh_req = 1'b1;
    @(negedge clk);
    refresh_req = 1'b0;
    wait_result();
    check("R8 result valid", got_v, 1);
    check("R9 pulse width", upd_valid, 1);
    @(negedge clk);
    check("R9 single cycle", upd_valid, 0);
    check("R8 idle after result", busy, 0);
    begin
      int extra = 0;
      for (int i = 0; i < 80; i++) begin
        @(negedge clk);
        if (upd_valid || upd_err) extra++;
      end
      check("R8 no extra result", extra, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule